// File: doc/BRIEF.md
# Byte Load/Store Five-Stage Pipeline

This block is a small in-order processor pipeline with five stages: fetch, decode, execute, memory access and write-back. It runs four instructions: register add, register subtract, load byte and store byte. An external source presents one 32-bit instruction word per cycle together with a valid strobe. A start-address input seeds the program counter. The block holds a 32-entry register file, a 2048-byte data memory and four stage registers, one between each pair of adjacent stages. It has no branches, no hazard detection, no forwarding and no stalls. The program must place enough all-zero bubble words between dependent instructions.

Debug outputs serve observation and test. These are a combinational read port into the register file, a combinational read port into the data memory, the contents of the fetch/decode stage register, the execute/memory result, and the write-back request held in the last stage register.

Top module: `pipe_core`

## Requirements
- R1: While reset is low, and after it, no write-back is requested and the fetch stage register holds a zero word. Register i holds 0x100 + i. Data memory byte a holds the low eight bits of a.
- R2: Each cycle with instr_valid high advances the program counter by 4 and shows it on dbg_ifid_pc. The first valid fetch after reset shows start_pc + 4. A cycle with instr_valid low leaves the program counter unchanged and loads the all-zero word into the fetch stage register, whatever instr_word carries.
- R3: The word 0x00000000 is a bubble. It flows down the pipe with all-zero control and writes neither a register nor memory.
- R4: An instruction with bits [31:26] = 0 and function bits [5:0] = 0x20 writes rs + rt into rd. The fields are rs = bits [25:21], rt = bits [20:16] and rd = bits [15:11].
- R5: An instruction with bits [31:26] = 0 and function bits [5:0] = 0x22 writes rs − rt into rd, with 32-bit wrap-around.
- R6: An instruction with any nonzero opcode other than 0x28 is a byte load. It reads the byte at address (rs + sign-extended bits [15:0]) modulo 2048, sign-extends it to 32 bits and writes it into rt.
- R7: Opcode 0x28 is a byte store. It writes the low byte of rt to address (rs + sign-extended bits [15:0]) modulo 2048 and writes no register. A load fetched in the next cycle from the same address returns the stored byte.
- R8: An instruction fetched at clock edge k presents its write-back on dbg_wb_we, dbg_wb_idx and dbg_wb_data after edge k+3. The register file takes the value at edge k+4.
- R9: When decode reads a register in the same cycle that write-back targets it, decode gets the old value. A reader placed after exactly two bubbles sees the old value. A reader placed after three bubbles sees the new value.
- R10: dbg_reg_val shows register dbg_reg_sel, and dbg_mem_val shows memory byte dbg_mem_sel, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_pc | input | 32 | Address of the first instruction |
| instr_valid | input | 1 | instr_word carries an instruction this cycle |
| instr_word | input | 32 | Instruction word |
| dbg_reg_sel | input | 5 | Register file debug read index |
| dbg_reg_val | output | 32 | Register selected by dbg_reg_sel |
| dbg_mem_sel | input | 11 | Data memory debug read address |
| dbg_mem_val | output | 8 | Byte at dbg_mem_sel |
| dbg_ifid_pc | output | 32 | Incremented PC held in the fetch/decode stage register |
| dbg_ifid_instr | output | 32 | Instruction word held in the fetch/decode stage register |
| dbg_exmem_alu | output | 32 | ALU result held in the execute/memory stage register |
| dbg_wb_we | output | 1 | Write-back request in the memory/write-back stage register |
| dbg_wb_idx | output | 5 | Destination register of that request |
| dbg_wb_data | output | 32 | Value to be written by that request |

## Verification
Two events can land in the same cycle: write-back into a register, and decode reading that same register. The bench provokes this by issuing an add to r5 and then exactly two bubbles. It then issues an instruction that reads r5. The scoreboard expects that reader to produce the value r5 held before the add. A second reader placed after three bubbles must see the new value. A store followed at once by a load from the same byte exercises the neighbouring case in data memory. There, the memory write from one instruction and the memory read of the next fall on consecutive edges.

// File: rtl/pipe_pkg.sv
// Shared constants and stage register types for the five-stage byte
// load/store pipeline. Assumes a 32-bit word and a power-of-two memory.
package pipe_pkg;
    localparam int XLEN      = 32;
    localparam int NREG      = 32;
    localparam int RIDX      = $clog2(NREG);
    localparam int MEM_BYTES = 2048;
    localparam int MAW       = $clog2(MEM_BYTES);
    localparam int BYTE_W    = 8;
    localparam int IMM_W     = 16;
    localparam int OP_LSB    = 26;
    localparam int OP_W      = 6;
    localparam int RS_LSB    = 21;
    localparam int RT_LSB    = 16;
    localparam int RD_LSB    = 11;
    localparam int FN_W      = 6;

    localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OP_STB   = 6'h28;
    localparam logic [FN_W-1:0] FN_SUB   = 6'h22;
    localparam logic [XLEN-1:0] PC_STEP  = 32'd4;
    localparam logic [XLEN-1:0] REG_INIT = 32'h100;

    // Full decoded control, consumed in execute.
    typedef struct packed {
        logic reg_dst;
        logic alu_sub;
        logic alu_imm;
        logic mem_rd;
        logic mem_wr;
        logic mem_to_reg;
        logic reg_wr;
    } ctrl_t;

    // Control still needed from memory access onward.
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic mem_to_reg;
        logic reg_wr;
    } mctl_t;

    // Control still needed in write-back.
    typedef struct packed {
        logic mem_to_reg;
        logic reg_wr;
    } wctl_t;

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] pc;
    } ifid_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [XLEN-1:0] rs_val;
        logic [XLEN-1:0] rt_val;
        logic [XLEN-1:0] imm;
        logic [RIDX-1:0] rt_idx;
        logic [RIDX-1:0] rd_idx;
    } idex_t;

    typedef struct packed {
        mctl_t             ctrl;
        logic [XLEN-1:0]   alu;
        logic [BYTE_W-1:0] st_byte;
        logic [RIDX-1:0]   dst;
    } exmem_t;

    typedef struct packed {
        wctl_t           ctrl;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] ld_val;
        logic [RIDX-1:0] dst;
    } memwb_t;
endpackage

// File: rtl/pipe_decode.sv
// Instruction decoder: turns a 32-bit word into stage control.
// Assumes: zero word is a bubble; opcode 0 is register format;
// opcode OP_STB is a byte store; any other opcode is a byte load.
module pipe_decode
    import pipe_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [OP_W-1:0] opcode;
    logic [FN_W-1:0] funct;

    assign opcode = instr[OP_LSB +: OP_W];
    assign funct  = instr[FN_W-1:0];

    // Combinational control generation for the four instruction kinds.
    always_comb begin
        ctrl = '0;
        if (instr == '0) begin
            ctrl = '0;
        end else if (opcode == OP_RTYPE) begin
            ctrl.reg_dst = 1'b1;
            ctrl.alu_sub = (funct == FN_SUB);
            ctrl.reg_wr  = 1'b1;
        end else if (opcode == OP_STB) begin
            ctrl.alu_imm = 1'b1;
            ctrl.mem_wr  = 1'b1;
        end else begin
            ctrl.alu_imm    = 1'b1;
            ctrl.mem_rd     = 1'b1;
            ctrl.mem_to_reg = 1'b1;
            ctrl.reg_wr     = 1'b1;
        end
    end
endmodule

// File: rtl/pipe_regfile.sv
// Register file: two decode read ports, one debug read port, one write
// port. Reads see the array before the edge (no internal bypass).
// Reset loads entry i with INIT_BASE + i.
module pipe_regfile #(
    parameter int                W         = 32,
    parameter int                DEPTH     = 32,
    parameter logic [W-1:0]      INIT_BASE = 32'h100,
    localparam int               IW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_a_idx,
    output logic [W-1:0]  rd_a,
    input  logic [IW-1:0] rd_b_idx,
    output logic [W-1:0]  rd_b,
    input  logic [IW-1:0] dbg_idx,
    output logic [W-1:0]  dbg_val
);
    logic [W-1:0] regs_q [DEPTH];

    // Per-entry storage: reset pattern, then write-back when addressed.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi] <= INIT_BASE + W'(gi);
            end else if (wr_en && (wr_idx == IW'(gi))) begin
                regs_q[gi] <= wr_data;
            end
        end
    end

    assign rd_a    = regs_q[rd_a_idx];
    assign rd_b    = regs_q[rd_b_idx];
    assign dbg_val = regs_q[dbg_idx];
endmodule

// File: rtl/pipe_datamem.sv
// Byte-wide data memory with one write port and two combinational read
// ports (pipeline load and debug). Reset fills byte a with a[7:0].
module pipe_datamem #(
    parameter int  DEPTH = 2048,
    parameter int  BW    = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wr_data,
    output logic [BW-1:0] rd_data,
    input  logic [AW-1:0] dbg_addr,
    output logic [BW-1:0] dbg_data
);
    logic [BW-1:0] mem_q [DEPTH];

    // Storage: address pattern on reset, byte store otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem_q[a] <= BW'(a);
            end
        end else if (wr_en) begin
            mem_q[addr] <= wr_data;
        end
    end

    assign rd_data  = mem_q[addr];
    assign dbg_data = mem_q[dbg_addr];
endmodule

// File: rtl/pipe_core.sv
// Five-stage in-order pipeline for add, sub, byte load and byte store.
// Assumes software spaces dependent instructions with bubbles: there is
// no forwarding, no stall and no branch. All stage registers advance
// together on every rising edge; synchronous active-low reset clears
// every control field to the bubble encoding.
module pipe_core
    import pipe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   start_pc,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   instr_word,
    input  logic [RIDX-1:0]   dbg_reg_sel,
    output logic [XLEN-1:0]   dbg_reg_val,
    input  logic [MAW-1:0]    dbg_mem_sel,
    output logic [BYTE_W-1:0] dbg_mem_val,
    output logic [XLEN-1:0]   dbg_ifid_pc,
    output logic [XLEN-1:0]   dbg_ifid_instr,
    output logic [XLEN-1:0]   dbg_exmem_alu,
    output logic              dbg_wb_we,
    output logic [RIDX-1:0]   dbg_wb_idx,
    output logic [XLEN-1:0]   dbg_wb_data
);
    ifid_t  ifid_q;
    idex_t  idex_q;
    exmem_t exmem_q;
    memwb_t memwb_q;
    logic   started_q;

    // ---------------- fetch ----------------
    logic [XLEN-1:0] pc_base;
    assign pc_base = started_q ? ifid_q.pc : start_pc;

    // Fetch stage register: capture word (or bubble) and advance the PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifid_q    <= '0;
            started_q <= 1'b0;
        end else begin
            ifid_q.instr <= instr_valid ? instr_word : '0;
            if (instr_valid) begin
                ifid_q.pc <= pc_base + PC_STEP;
                started_q <= 1'b1;
            end
        end
    end

    // ---------------- decode ----------------
    ctrl_t           dec_ctrl;
    logic [RIDX-1:0] dec_rs, dec_rt, dec_rd;
    logic [XLEN-1:0] rf_rs_val, rf_rt_val;
    logic [XLEN-1:0] dec_imm;
    logic            wb_we;
    logic [XLEN-1:0] wb_data;

    pipe_decode u_decode (
        .instr (ifid_q.instr),
        .ctrl  (dec_ctrl)
    );

    assign dec_rs  = ifid_q.instr[RS_LSB +: RIDX];
    assign dec_rt  = ifid_q.instr[RT_LSB +: RIDX];
    assign dec_rd  = ifid_q.instr[RD_LSB +: RIDX];
    assign dec_imm = {{(XLEN-IMM_W){ifid_q.instr[IMM_W-1]}}, ifid_q.instr[IMM_W-1:0]};

    pipe_regfile #(
        .W         (XLEN),
        .DEPTH     (NREG),
        .INIT_BASE (REG_INIT)
    ) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wb_we),
        .wr_idx   (memwb_q.dst),
        .wr_data  (wb_data),
        .rd_a_idx (dec_rs),
        .rd_a     (rf_rs_val),
        .rd_b_idx (dec_rt),
        .rd_b     (rf_rt_val),
        .dbg_idx  (dbg_reg_sel),
        .dbg_val  (dbg_reg_val)
    );

    // Decode/execute stage register: operands, immediate and control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex_q <= '0;
        end else begin
            idex_q.ctrl   <= dec_ctrl;
            idex_q.rs_val <= rf_rs_val;
            idex_q.rt_val <= rf_rt_val;
            idex_q.imm    <= dec_imm;
            idex_q.rt_idx <= dec_rt;
            idex_q.rd_idx <= dec_rd;
        end
    end

    // ---------------- execute ----------------
    logic [XLEN-1:0] ex_opb, ex_alu;
    logic [RIDX-1:0] ex_dst;

    // ALU: second operand is rt or the offset; subtract or add.
    always_comb begin
        ex_opb = idex_q.ctrl.alu_imm ? idex_q.imm : idex_q.rt_val;
        ex_alu = idex_q.ctrl.alu_sub ? (idex_q.rs_val - ex_opb)
                                     : (idex_q.rs_val + ex_opb);
        ex_dst = idex_q.ctrl.reg_dst ? idex_q.rd_idx : idex_q.rt_idx;
    end

    // Execute/memory stage register: result, store byte, destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exmem_q <= '0;
        end else begin
            exmem_q.ctrl.mem_rd     <= idex_q.ctrl.mem_rd;
            exmem_q.ctrl.mem_wr     <= idex_q.ctrl.mem_wr;
            exmem_q.ctrl.mem_to_reg <= idex_q.ctrl.mem_to_reg;
            exmem_q.ctrl.reg_wr     <= idex_q.ctrl.reg_wr;
            exmem_q.alu             <= ex_alu;
            exmem_q.st_byte         <= idex_q.rt_val[BYTE_W-1:0];
            exmem_q.dst             <= ex_dst;
        end
    end

    // ---------------- memory access ----------------
    logic [BYTE_W-1:0] mem_byte;
    logic [XLEN-1:0]   mem_ld_ext;

    pipe_datamem #(
        .DEPTH (MEM_BYTES),
        .BW    (BYTE_W)
    ) u_datamem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (exmem_q.ctrl.mem_wr),
        .addr     (exmem_q.alu[MAW-1:0]),
        .wr_data  (exmem_q.st_byte),
        .rd_data  (mem_byte),
        .dbg_addr (dbg_mem_sel),
        .dbg_data (dbg_mem_val)
    );

    assign mem_ld_ext = exmem_q.ctrl.mem_rd
                      ? {{(XLEN-BYTE_W){mem_byte[BYTE_W-1]}}, mem_byte}
                      : '0;

    // Memory/write-back stage register: load value, ALU value, target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            memwb_q <= '0;
        end else begin
            memwb_q.ctrl.mem_to_reg <= exmem_q.ctrl.mem_to_reg;
            memwb_q.ctrl.reg_wr     <= exmem_q.ctrl.reg_wr;
            memwb_q.alu             <= exmem_q.alu;
            memwb_q.ld_val          <= mem_ld_ext;
            memwb_q.dst             <= exmem_q.dst;
        end
    end

    // ---------------- write-back ----------------
    assign wb_we   = memwb_q.ctrl.reg_wr;
    assign wb_data = memwb_q.ctrl.mem_to_reg ? memwb_q.ld_val : memwb_q.alu;

    assign dbg_ifid_pc    = ifid_q.pc;
    assign dbg_ifid_instr = ifid_q.instr;
    assign dbg_exmem_alu  = exmem_q.alu;
    assign dbg_wb_we      = wb_we;
    assign dbg_wb_idx     = memwb_q.dst;
    assign dbg_wb_data    = wb_data;
endmodule

// File: rtl/pipe_core_chk.sv
// Property checker for pipe_core, attached by bind below. It watches the
// fetch handshake, bubble flow and write-back landing at the ports.
module pipe_core_chk
    import pipe_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] start_pc,
    input logic            instr_valid,
    input logic [XLEN-1:0] instr_word,
    input logic [RIDX-1:0] dbg_reg_sel,
    input logic [XLEN-1:0] dbg_reg_val,
    input logic [XLEN-1:0] dbg_ifid_pc,
    input logic [XLEN-1:0] dbg_ifid_instr,
    input logic            dbg_wb_we,
    input logic [RIDX-1:0] dbg_wb_idx,
    input logic [XLEN-1:0] dbg_wb_data
);
    logic [2:0] since_rst;
    logic       seen_q;

    // Cycles since reset release (saturating) and first-fetch tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            seen_q    <= 1'b0;
        end else begin
            if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
            if (instr_valid) seen_q <= 1'b1;
        end
    end

    assert_first_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !seen_q) |=> (dbg_ifid_pc == $past(start_pc) + PC_STEP));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && seen_q) |=> (dbg_ifid_pc == $past(dbg_ifid_pc) + PC_STEP));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(dbg_ifid_pc) && (dbg_ifid_instr == '0)));

    assert_bubble_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && $past(instr_valid && (instr_word == '0), 4)) |-> !dbg_wb_we);

    assert_wb_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wb_we && (dbg_reg_sel == dbg_wb_idx))
        |=> (!$stable(dbg_reg_sel) || (dbg_reg_val == $past(dbg_wb_data))));
endmodule

bind pipe_core pipe_core_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_pc       (start_pc),
    .instr_valid    (instr_valid),
    .instr_word     (instr_word),
    .dbg_reg_sel    (dbg_reg_sel),
    .dbg_reg_val    (dbg_reg_val),
    .dbg_ifid_pc    (dbg_ifid_pc),
    .dbg_ifid_instr (dbg_ifid_instr),
    .dbg_wb_we      (dbg_wb_we),
    .dbg_wb_idx     (dbg_wb_idx),
    .dbg_wb_data    (dbg_wb_data)
);

// File: tb/pipe_core_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected write-backs into a queue,
// a negedge monitor pops and compares them as they leave the pipe.
module pipe_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] start_pc = 32'h0007_0000;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_val;
    logic [10:0] dbg_mem_sel = '0;
    logic [7:0]  dbg_mem_val;
    logic [31:0] dbg_ifid_pc, dbg_ifid_instr, dbg_exmem_alu, dbg_wb_data;
    logic        dbg_wb_we;
    logic [4:0]  dbg_wb_idx;

    pipe_core dut_i (
        .clk(clk), .rst_n(rst_n), .start_pc(start_pc),
        .instr_valid(instr_valid), .instr_word(instr_word),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
        .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val),
        .dbg_ifid_pc(dbg_ifid_pc), .dbg_ifid_instr(dbg_ifid_instr),
        .dbg_exmem_alu(dbg_exmem_alu), .dbg_wb_we(dbg_wb_we),
        .dbg_wb_idx(dbg_wb_idx), .dbg_wb_data(dbg_wb_data)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [4:0]  idx;
        logic [31:0] data;
        int          cyc;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          cnt     = 0;
    bit          done    = 0;
    logic [31:0] mreg [32];
    logic [7:0]  mmem [2048];
    logic [31:0] exp_pc = '0;
    bit          started = 0;

    always @(posedge clk) cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rtype(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'h00, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] off);
        return {op, rs, rt, off};
    endfunction

    // Driver: present one fetch slot, queue its write-back, check fetch (R2).
    task automatic issue(input logic v, input logic [31:0] w, input bit we,
                         input logic [4:0] idx, input logic [31:0] data, input string req);
        instr_valid = v;
        instr_word  = w;
        if (we) sb_q.push_back('{idx: idx, data: data, cyc: cnt, req: req});
        if (v) begin
            exp_pc  = (started ? exp_pc : start_pc) + 32'd4;
            started = 1;
        end
        @(posedge clk);
        #1;
        check(dbg_ifid_pc == exp_pc, "R2", "fetch pc", dbg_ifid_pc, exp_pc);
        check(dbg_ifid_instr == (v ? w : 32'h0), "R2", "fetch word",
              dbg_ifid_instr, v ? w : 32'h0);
        @(negedge clk);
    endtask

    task automatic bubbles(input int n);
        for (int i = 0; i < n; i++) issue(1'b1, 32'h0, 0, 5'd0, 32'h0, "R3");
    endtask

    task automatic op_add(input logic [4:0] rd, rs, rt);
        logic [31:0] v;
        v = mreg[rs] + mreg[rt];
        issue(1'b1, rtype(rs, rt, rd, 6'h20), 1, rd, v, "R4");
        mreg[rd] = v;
    endtask

    task automatic op_sub(input logic [4:0] rd, rs, rt);
        logic [31:0] v;
        v = mreg[rs] - mreg[rt];
        issue(1'b1, rtype(rs, rt, rd, 6'h22), 1, rd, v, "R5");
        mreg[rd] = v;
    endtask

    task automatic op_lb(input logic [5:0] op, input logic [4:0] rt, rs, input logic [15:0] off);
        logic [31:0] a;
        logic [31:0] v;
        a = mreg[rs] + {{16{off[15]}}, off};
        v = {{24{mmem[a[10:0]][7]}}, mmem[a[10:0]]};
        issue(1'b1, itype(op, rs, rt, off), 1, rt, v, "R6");
        mreg[rt] = v;
    endtask

    task automatic op_sb(input logic [4:0] rt, rs, input logic [15:0] off);
        logic [31:0] a;
        a = mreg[rs] + {{16{off[15]}}, off};
        issue(1'b1, itype(6'h28, rs, rt, off), 0, 5'd0, 32'h0, "R7");
        mmem[a[10:0]] = mreg[rt][7:0];
    endtask

    // Monitor: compare each write-back against the scoreboard (R3, R8).
    always @(negedge clk) begin
        if (rst_n && dbg_wb_we) begin
            if (sb_q.size() == 0) begin
                check(0, "R3", "unexpected write-back to reg", 32'(dbg_wb_idx), 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(dbg_wb_idx == e.idx, e.req, "write-back index", 32'(dbg_wb_idx), 32'(e.idx));
                check(dbg_wb_data == e.data, e.req, "write-back data", dbg_wb_data, e.data);
                check(cnt == e.cyc + 4, "R8", "write-back latency", 32'(cnt), 32'(e.cyc + 4));
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] old5;
        for (int i = 0; i < 32; i++) mreg[i] = 32'h100 + 32'(i);
        for (int a = 0; a < 2048; a++) mmem[a] = 8'(a);

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state observed while reset is held.
        check(dbg_wb_we == 1'b0, "R1", "wb_we in reset", 32'(dbg_wb_we), 32'h0);
        check(dbg_ifid_instr == 32'h0, "R1", "ifid word in reset", dbg_ifid_instr, 32'h0);
        dbg_reg_sel = 5'd3;
        dbg_mem_sel = 11'h185;
        #1;
        check(dbg_reg_val == 32'h103, "R1", "reg3 reset", dbg_reg_val, 32'h103);
        check(dbg_mem_val == 8'h85, "R10", "mem 0x185 reset", 32'(dbg_mem_val), 32'h85);
        dbg_reg_sel = 5'd0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2: invalid slot before first fetch holds the PC and drops the word.
        issue(1'b0, 32'hDEAD_BEEF, 0, 5'd0, 32'h0, "R2");
        // R4/R5: arithmetic.
        op_add(5'd3, 5'd1, 5'd2);          bubbles(3);
        op_sub(5'd4, 5'd1, 5'd2);          bubbles(3);   // wraps to 0xFFFFFFFF
        // R6: loads, negative byte and negative offset.
        op_lb(6'h20, 5'd7, 5'd0, 16'h0085); bubbles(3);
        op_lb(6'h23, 5'd8, 5'd10, 16'hFFFC); bubbles(3);
        // R2: invalid slot in the middle with junk on the word.
        issue(1'b0, 32'h1234_5678, 0, 5'd0, 32'h0, "R2");
        // R7: store then reload.
        op_sb(5'd3, 5'd1, 16'h0010);       bubbles(3);
        op_lb(6'h20, 5'd9, 5'd1, 16'h0010); bubbles(3);
        // R7: back-to-back store and load of the same byte.
        op_sb(5'd4, 5'd0, 16'h0120);
        op_lb(6'h20, 5'd11, 5'd0, 16'h0120); bubbles(3);
        // R6: address wraps modulo 2048.
        op_lb(6'h20, 5'd12, 5'd2, 16'h07FF); bubbles(3);
        // R9: same-cycle write-back and read returns the old value.
        old5 = mreg[5];
        op_add(5'd5, 5'd1, 5'd2);
        bubbles(2);
        issue(1'b1, rtype(5'd5, 5'd0, 5'd6, 6'h20), 1, 5'd6, old5 + mreg[0], "R9");
        mreg[6] = old5 + mreg[0];
        bubbles(3);
        op_add(5'd13, 5'd5, 5'd0);         // R9: three bubbles see the new value
        bubbles(6);

        check(sb_q.size() == 0, "R3", "scoreboard drained", 32'(sb_q.size()), 32'h0);

        // R10: register file and memory through the debug ports.
        for (int i = 0; i < 32; i++) begin
            dbg_reg_sel = 5'(i);
            #1;
            check(dbg_reg_val == mreg[i], "R10", $sformatf("reg %0d", i), dbg_reg_val, mreg[i]);
        end
        for (int k = 0; k < 6; k++) begin
            logic [10:0] a;
            a = (k == 0) ? 11'h111 : (k == 1) ? 11'h220 : (k == 2) ? 11'h000 :
                (k == 3) ? 11'h7FF : (k == 4) ? 11'h110 : 11'h221;
            dbg_mem_sel = a;
            #1;
            check(dbg_mem_val == mmem[a], "R7", $sformatf("mem %h", a),
                  32'(dbg_mem_val), 32'(mmem[a]));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule